// File: doc/BRIEF.md
# Four-Lane 7:1 Serial-to-Parallel Video Word Recovery

This block turns four serial data lanes into one 28-bit parallel word per pixel period. It runs on a bit-rate clock seven times faster than the pixel clock. Alongside the four data lanes it receives a copy of the slow clock lane, already sampled in the fast domain. Each lane fills its own seven-bit shift register. A rising transition on the sampled clock lane marks the start of a frame, and a phase counter is realigned to that transition. When the seventh bit of a frame arrives, the four captures are scattered onto fixed positions of the output word, and a one-cycle valid strobe is raised.

The positions are interleaved rather than concatenated. This is how the upstream serializer packs three colour channels, the sync flags and a spare bit. The block does not interpret the bits in any way; it only puts each one in its place.

An active-low shutdown input clears every register. Output is held back until the framing has been confirmed. A clock-lane transition that lands off the frame grid raises a sticky framing-error flag.

Top module: `vdes_top`

## Requirements
- R1: Each lane is deserialized over seven fast-clock cycles. The bit a lane carries in the rising-transition cycle is serial bit 0, and the next six cycles carry bits 1 to 6.
- R2: Serial bits 0..6 go to these output positions. Lane 0: 0,1,2,3,4,6,7. Lane 1: 8,9,12,13,14,15,18. Lane 2: 19,20,21,22,24,25,26. Lane 3: 27,5,10,11,16,17,23.
- R3: A frame boundary is a cycle in which the sampled clock lane is 1 after having been 0 in the cycle before. Such a boundary realigns the phase counter so that this cycle carries serial bit 0.
- R4: On the clock edge that samples serial bit 6, while framing is locked, `par_out` is loaded and `par_vld` is high for exactly that one cycle. At all other times `par_out` holds its value.
- R5: After shutdown is released, `par_out` stays 0 and `par_vld` stays low until a boundary arrives a whole number of frames after a previous boundary. The frame that starts at that boundary is the first one output.
- R6: A boundary that arrives at any phase other than the start of a frame sets `frame_err`. The flag stays set until shutdown, locking is dropped, and the frame that starts at that boundary is not output. The first boundary after shutdown never sets the flag.
- R7: While `shdn_n` is 0, the next clock edge forces `par_out`, `par_vld`, `frame_err` and all internal state to 0, whatever the lane inputs are doing.
- R8: While locked, if no boundary arrives, the phase counter keeps running. A new word is then delivered every seven cycles, and a later boundary that falls on the grid raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Bit-rate clock, seven times the pixel rate |
| shdn_n | input | 1 | Active-low shutdown and synchronous clear |
| clk_lane_smp | input | 1 | Slow clock lane sampled in the fast domain |
| lane_in | input | 4 | Serial data lanes, bit n is lane n |
| par_out | output | 28 | Recovered parallel word |
| par_vld | output | 1 | One-cycle strobe marking a new `par_out` |
| frame_err | output | 1 | Sticky flag for a misplaced clock-lane transition |

## Verification
The hardest state to reach is a boundary that arrives mid-frame while the block is locked. That boundary must set the error and drop the lock, and it must be followed at once by a correctly spaced boundary that brings output back. The stimulus gets there by sending a deliberately shortened four-cycle frame with its own rising transition, then a full frame whose transition therefore falls at phase four. A further full frame then shows that re-locking works while the error flag is still held. Freewheeling is reached by sending whole frames with the clock lane held low. The check that follows confirms that a transition which later returns on the grid raises no error.

// File: rtl/vdes_pkg.sv
package vdes_pkg;
  localparam int LANES  = 4;
  localparam int BITS   = 7;
  localparam int OUT_W  = LANES * BITS;
  localparam int PH_W   = $clog2(BITS);
  localparam int POS_W  = $clog2(OUT_W);

  // output position of serial bit b on lane l
  localparam logic [POS_W-1:0] LANE_POS [LANES][BITS] = '{
    '{5'd0,  5'd1,  5'd2,  5'd3,  5'd4,  5'd6,  5'd7 },
    '{5'd8,  5'd9,  5'd12, 5'd13, 5'd14, 5'd15, 5'd18},
    '{5'd19, 5'd20, 5'd21, 5'd22, 5'd24, 5'd25, 5'd26},
    '{5'd27, 5'd5,  5'd10, 5'd11, 5'd16, 5'd17, 5'd23}
  };
endpackage

// File: rtl/vdes_lane.sv
module vdes_lane #(
  parameter int BITS = 7
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            din,
  output logic [BITS-1:0] word_o
);
  logic [BITS-1:0] sreg_q;

  // serial bit 0 lands in index 0 once the seventh bit is shifted in
  assign word_o = {din, sreg_q[BITS-1:1]};

  always_ff @(posedge clk) begin
    if (clr) sreg_q <= '0;
    else     sreg_q <= word_o;
  end
endmodule

// File: rtl/vdes_framer.sv
module vdes_framer #(
  parameter int BITS = 7,
  parameter int PH_W = 3
) (
  input  logic clk,
  input  logic clr,
  input  logic lane_clk,
  output logic last_bit,
  output logic lock_q,
  output logic err_q
);
  localparam logic [PH_W-1:0] LAST = PH_W'(BITS - 1);

  logic            prev_q;
  logic            seen_q;
  logic [PH_W-1:0] cnt_q;
  logic [PH_W-1:0] idx;
  logic            rise_det;

  assign rise_det = lane_clk & ~prev_q;
  assign idx      = rise_det ? '0 : cnt_q;
  assign last_bit = (idx == LAST);

  always_ff @(posedge clk) begin
    if (clr) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= lane_clk;
      cnt_q  <= last_bit ? '0 : idx + 1'b1;
      if (rise_det) begin
        seen_q <= 1'b1;
        if (seen_q && cnt_q != '0) begin
          err_q  <= 1'b1;
          lock_q <= 1'b0;
        end else if (seen_q) begin
          lock_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vdes_remap.sv
module vdes_remap
  import vdes_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int N_BITS  = BITS
) (
  input  logic [N_LANES*N_BITS-1:0] lanes_i,
  output logic [N_LANES*N_BITS-1:0] wide_o
);
  always_comb begin
    wide_o = '0;
    for (int l = 0; l < N_LANES; l++) begin
      for (int b = 0; b < N_BITS; b++) begin
        wide_o[LANE_POS[l][b]] = lanes_i[l*N_BITS + b];
      end
    end
  end
endmodule

// File: rtl/vdes_top.sv
module vdes_top
  import vdes_pkg::*;
(
  input  logic             clk_fast,
  input  logic             shdn_n,
  input  logic             clk_lane_smp,
  input  logic [LANES-1:0] lane_in,
  output logic [OUT_W-1:0] par_out,
  output logic             par_vld,
  output logic             frame_err
);
  logic             clr;
  logic             last_w;
  logic             lock_w;
  logic             err_w;
  logic             load_w;
  logic [OUT_W-1:0] lane_flat;
  logic [OUT_W-1:0] mapped;

  assign clr = ~shdn_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BITS-1:0] word;
    vdes_lane #(.BITS(BITS)) u_lane (
      .clk    (clk_fast),
      .clr    (clr),
      .din    (lane_in[g]),
      .word_o (word)
    );
    assign lane_flat[g*BITS +: BITS] = word;
  end

  vdes_framer #(.BITS(BITS), .PH_W(PH_W)) u_framer (
    .clk      (clk_fast),
    .clr      (clr),
    .lane_clk (clk_lane_smp),
    .last_bit (last_w),
    .lock_q   (lock_w),
    .err_q    (err_w)
  );

  vdes_remap #(.N_LANES(LANES), .N_BITS(BITS)) u_remap (
    .lanes_i (lane_flat),
    .wide_o  (mapped)
  );

  assign load_w    = last_w & lock_w;
  assign frame_err = err_w;

  always_ff @(posedge clk_fast) begin
    if (clr) begin
      par_out <= '0;
      par_vld <= 1'b0;
    end else begin
      par_vld <= load_w;
      if (load_w) par_out <= mapped;
    end
  end
endmodule

// File: rtl/vdes_chk.sv
module vdes_chk
  import vdes_pkg::*;
(
  input logic             clk_fast,
  input logic             shdn_n,
  input logic             clk_lane_smp,
  input logic [OUT_W-1:0] par_out,
  input logic             par_vld,
  input logic             frame_err,
  input logic             lock_w
);
  a_r7_shutdown_clears: assert property (@(posedge clk_fast)
    !shdn_n |=> (par_out == '0 && !par_vld && !frame_err));

  a_r4_single_pulse: assert property (@(posedge clk_fast) disable iff (!shdn_n)
    par_vld |=> !par_vld);

  a_r4_hold_between: assert property (@(posedge clk_fast) disable iff (!shdn_n)
    !par_vld |-> $stable(par_out));

  a_r5_out_needs_lock: assert property (@(posedge clk_fast) disable iff (!shdn_n)
    par_vld |-> $past(lock_w));

  a_r6_err_sticky: assert property (@(posedge clk_fast) disable iff (!shdn_n)
    frame_err |=> frame_err);

  a_r6_err_on_rise: assert property (@(posedge clk_fast) disable iff (!shdn_n)
    $rose(frame_err) |-> ($past(clk_lane_smp) && !$past(clk_lane_smp, 2)));
endmodule

bind vdes_top vdes_chk u_chk (
  .clk_fast     (clk_fast),
  .shdn_n       (shdn_n),
  .clk_lane_smp (clk_lane_smp),
  .par_out      (par_out),
  .par_vld      (par_vld),
  .frame_err    (frame_err),
  .lock_w       (lock_w)
);

// File: tb/test_vdes_top.sv
module test_vdes_top;
  logic        clk_fast = 1'b0;
  logic        shdn_n;
  logic        clk_lane_smp;
  logic [3:0]  lane_in;
  logic [27:0] par_out;
  logic        par_vld;
  logic        frame_err;

  always #5 clk_fast = ~clk_fast;

  vdes_top i_vdes_top (
    .clk_fast     (clk_fast),
    .shdn_n       (shdn_n),
    .clk_lane_smp (clk_lane_smp),
    .lane_in      (lane_in),
    .par_out      (par_out),
    .par_vld      (par_vld),
    .frame_err    (frame_err)
  );

  // serial bit k of lane l goes to output position MAP[l][k] (R2)
  localparam int MAP [4][7] = '{
    '{0, 1, 2, 3, 4, 6, 7},
    '{8, 9, 12, 13, 14, 15, 18},
    '{19, 20, 21, 22, 24, 25, 26},
    '{27, 5, 10, 11, 16, 17, 23}
  };

  localparam logic [27:0] VEC [8] = '{
    28'h0000000, 28'hFFFFFFF, 28'h0000020, 28'h8000000,
    28'h0800000, 28'h5555555, 28'hAAAAAAA, 28'h1234567
  };

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        pend_vld;
  logic [27:0] pend_word;
  logic [27:0] hold_word;
  logic        exp_err;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // result slot for the previous frame (R4, R5, R6)
  task automatic slot_check();
    chk("R4 valid strobe", {31'd0, par_vld}, {31'd0, pend_vld});
    if (pend_vld) hold_word = pend_word;
    chk("R2 R5 output word", {4'd0, par_out}, {4'd0, hold_word});
    chk("R6 frame_err", {31'd0, frame_err}, {31'd0, exp_err});
  endtask

  task automatic step_frame(input logic [27:0] w, input bit rise_en, input int len,
                            input bit exp_vld);
    for (int k = 0; k < len; k++) begin
      @(negedge clk_fast);
      if (k == 0) slot_check();
      if (k == 1) chk("R4 pulse one cycle", {31'd0, par_vld}, 32'd0);
      clk_lane_smp = rise_en && (k < (len + 1) / 2);
      for (int l = 0; l < 4; l++) lane_in[l] = w[MAP[l][k]];
    end
    pend_vld  = exp_vld;
    pend_word = w;
  endtask

  initial begin
    repeat (100000) @(posedge clk_fast);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    shdn_n = 1'b0; clk_lane_smp = 1'b0; lane_in = '0;
    pend_vld = 1'b0; pend_word = '0; hold_word = '0; exp_err = 1'b0;
    repeat (3) @(negedge clk_fast);
    // R7: reset state
    chk("R7 reset par_out", {4'd0, par_out}, 32'd0);
    chk("R7 reset par_vld", {31'd0, par_vld}, 32'd0);
    chk("R7 reset frame_err", {31'd0, frame_err}, 32'd0);
    shdn_n = 1'b1;

    // R5: first boundary only, nothing output, no error (R6)
    step_frame(28'hABCDEF0, 1, 7, 0);
    // R1 R2 R3: vector table, first vector locks
    for (int i = 0; i < 8; i++) step_frame(VEC[i], 1, 7, 1);

    // R8: freewheel without boundaries, then return on the grid
    step_frame(28'h0F0F0F0, 0, 7, 1);
    step_frame(28'h3C3C3C3, 0, 7, 1);
    step_frame(28'h1111111, 1, 7, 1);

    // R6: short frame puts next boundary at phase 4
    step_frame(28'h2222222, 1, 4, 0);
    step_frame(28'h4444444, 1, 7, 0);
    exp_err = 1'b1;
    step_frame(28'h6666666, 1, 7, 1);
    step_frame(28'h7654321, 1, 7, 1);
    @(negedge clk_fast);
    slot_check();

    // R7: shutdown with activity on the inputs
    shdn_n = 1'b0;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_fast);
      clk_lane_smp = k[0];
      lane_in = 4'hF ^ k[3:0];
    end
    @(negedge clk_fast);
    chk("R7 shutdown par_out", {4'd0, par_out}, 32'd0);
    chk("R7 shutdown par_vld", {31'd0, par_vld}, 32'd0);
    chk("R7 shutdown frame_err", {31'd0, frame_err}, 32'd0);
    clk_lane_smp = 1'b0;
    @(negedge clk_fast);
    shdn_n = 1'b1;
    pend_vld = 1'b0; hold_word = '0; exp_err = 1'b0;

    // R5: relock required after shutdown
    step_frame(28'h5A5A5A5, 1, 7, 0);
    step_frame(28'h0C0FFEE, 1, 7, 1);
    @(negedge clk_fast);
    slot_check();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule